// File: doc/BRIEF.md
# Framebuffer Mode Register Bank

This block is the register front end of a simple linear-framebuffer display controller. Software programs the screen geometry through a small bank of 16-bit registers. These cover an enable flag, colour depth, visible width and height, a virtual line width, and a panning origin. The bank also offers two read-only words: an identification constant and the installed video-memory size in 64 KiB units. A separate 32-bit extension window holds a byte-order selector for the framebuffer.

From the register contents the block continuously works out the active display mode. This covers the pixel format, bytes per pixel, width, height, line stride in bytes, start offset and total size of the visible surface. It also checks that the requested surface fits inside the installed memory. The result is registered and only replaced by a valid mode. A one-cycle `modeChanged` pulse tells the scan-out logic that it must reload its geometry. The bus is a single-cycle port: writes take effect at the clock edge and reads are combinational from the address.

Top module: `fb_mode_bank`

## Requirements
- R1: Address bit 9 clear selects the mode bank, whose 16-bit register index is the byte address shifted right by one (addr[8:1]). The indices are 1 enable, 2 depth, 3 width, 4 height, 5 virtual width, 6 X pan, 7 Y pan. A write stores wrData[15:0], and a read returns the stored value zero-extended to 32 bits.
- R2: Index 0 always reads 16'h4C46, and writes to it have no effect on that value.
- R3: Index 8 reads the installed memory size divided by 65536. The installed size is the parameter MEM_REQ_BYTES rounded up to a power of two, and the parameter must lie in the range 4 MiB to 256 MiB.
- R4: Any index of 9 or above reads 32'h0000FFFF. Writes to index 8 or above change no register.
- R5: The mode is valid only while bit 0 of the enable register is 1.
- R6: A depth of 16 gives 2 bytes per pixel with format code 1 (RGB565). A depth of 32 gives 4 bytes per pixel with format code 2 (xRGB8888, little endian) or code 3 (big endian). Any other depth makes the mode invalid.
- R7: Stride is the larger of the virtual width and the width, multiplied by the bytes per pixel. Size is the stride multiplied by the height.
- R8: Start offset is the X pan times the bytes per pixel, plus the Y pan times the stride.
- R9: The mode is invalid when the width or height is below 64, or when the start offset plus the size exceeds the installed memory size.
- R10: Address bit 9 set selects the extension window. A write of 32'hBEBEBEBE at window offset 4 selects big endian. A write of 32'h1E1E1E1E there selects little endian. Any other value leaves the selection unchanged. A read at offset 4 returns the code of the current selection, and reset selects little endian.
- R11: Extension offset 0 reads the window length 8, and every other extension offset except 4 reads 0.
- R12: The mode outputs and `modeValid` update on the clock edge after the register change. `modeChanged` is high for exactly that cycle when a valid mode differs from the last latched one. An invalid mode leaves the latched outputs unchanged, and re-enabling an identical mode raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | 10 | Byte address; bit 9 selects the extension window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| modeValid | output | 1 | Current registers describe a usable mode |
| modeChanged | output | 1 | One-cycle pulse when a new valid mode is latched |
| pixFormat | output | 2 | 0 none, 1 RGB565, 2 xRGB8888 LE, 3 xRGB8888 BE |
| bytesPerPix | output | 3 | Latched bytes per pixel |
| modeWidth | output | 16 | Latched visible width |
| modeHeight | output | 16 | Latched visible height |
| modeStride | output | 18 | Latched line stride in bytes |
| modeOffset | output | 36 | Latched start offset in bytes |
| modeSize | output | 36 | Latched surface size in bytes |

## Verification
The bench uses an 8 MiB memory that was requested as 5 MiB. A design that forgot the power-of-two rounding reports 80 instead of 128 blocks and accepts different geometries. One table entry fills memory exactly and the next one overruns it by four bytes, which catches a fit test that uses the wrong comparison or ignores the offset. A width of 63 and a depth of 24 must both fail validation. Another entry has a virtual width below the visible width, which exposes a stride built from the wrong operand. In the directed part, the pulse is sampled in the single cycle after the change, and disabling then re-enabling an identical mode must produce no pulse. The byte-order selector also receives a value that is neither code, and a design that decoded only one bit of it would flip endianness at that point.

// File: rtl/fb_mode_pkg.sv
package fb_mode_pkg;
  localparam int REG_W  = 16;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int GEO_W  = 36;
  localparam int STR_W  = 18;

  localparam logic [IDX_W-1:0] IDX_ID    = 8'd0;
  localparam logic [IDX_W-1:0] IDX_EN    = 8'd1;
  localparam logic [IDX_W-1:0] IDX_DEPTH = 8'd2;
  localparam logic [IDX_W-1:0] IDX_XRES  = 8'd3;
  localparam logic [IDX_W-1:0] IDX_YRES  = 8'd4;
  localparam logic [IDX_W-1:0] IDX_VIRTW = 8'd5;
  localparam logic [IDX_W-1:0] IDX_XPAN  = 8'd6;
  localparam logic [IDX_W-1:0] IDX_YPAN  = 8'd7;
  localparam logic [IDX_W-1:0] IDX_MEM   = 8'd8;
  localparam int               NUM_IDX   = 9;

  localparam logic [REG_W-1:0] ID_CODE      = 16'h4C46;
  localparam logic [BUS_W-1:0] ORDER_BIG    = 32'hBEBE_BEBE;
  localparam logic [BUS_W-1:0] ORDER_LITTLE = 32'h1E1E_1E1E;
  localparam logic [BUS_W-1:0] EXT_LEN      = 32'd8;
  localparam int               EXT_OFS_LEN  = 0;
  localparam int               EXT_OFS_ORD  = 4;
  localparam int               MIN_DIM      = 64;

  typedef enum logic [1:0] {
    FMT_NONE    = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_XRGB_LE = 2'd2,
    FMT_XRGB_BE = 2'd3
  } pixFmt_t;

  typedef struct packed {
    pixFmt_t          fmt;
    logic [2:0]       bpp;
    logic [REG_W-1:0] width;
    logic [REG_W-1:0] height;
    logic [STR_W-1:0] stride;
    logic [GEO_W-1:0] offset;
    logic [GEO_W-1:0] size;
  } modeInfo_t;

  typedef struct packed {
    logic modeWr;
    logic orderWr;
    logic latch;
  } ctlStrobe_t;

  function automatic longint unsigned pow2Ceil(input longint unsigned v);
    longint unsigned r;
    r = 1;
    while (r < v) r = r << 1;
    return r;
  endfunction
endpackage

// File: rtl/fb_mode_ctl.sv
module fb_mode_ctl
  import fb_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              curValid,
  input  logic              modeDiffers,
  output ctlStrobe_t        strobe,
  output logic              modeChanged
);
  logic extSel;
  assign extSel = addr[ADDR_W-1];

  always_comb begin
    strobe.modeWr  = wrEn && !extSel;
    strobe.orderWr = wrEn && extSel && (addr[ADDR_W-2:0] == (ADDR_W-1)'(EXT_OFS_ORD));
    strobe.latch   = curValid && modeDiffers;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeChanged <= 1'b0;
    else       modeChanged <= strobe.latch;
  end
endmodule

// File: rtl/fb_mode_dp.sv
module fb_mode_dp
  import fb_mode_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 64'd16777216
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              curValid,
  output logic              modeDiffers,
  output logic              validQ,
  output modeInfo_t         latched
);
  localparam logic [REG_W-1:0] MEM_BLOCKS = REG_W'(MEM_BYTES >> 16);
  localparam logic [GEO_W:0]   MEM_LIMIT  = (GEO_W+1)'(MEM_BYTES);

  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] regFile [1:NUM_IDX-2];
  logic             bigEnd;

  assign idx = addr[IDX_W:1];

  // one storage word per writable index
  for (genvar gi = 1; gi < NUM_IDX - 1; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) regFile[gi] <= '0;
      else if (strobe.modeWr && idx == IDX_W'(gi)) regFile[gi] <= wrData[REG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) bigEnd <= 1'b0;
    else if (strobe.orderWr) begin
      if (wrData == ORDER_BIG)         bigEnd <= 1'b1;
      else if (wrData == ORDER_LITTLE) bigEnd <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr[ADDR_W-1]) begin
      if (addr[ADDR_W-2:0] == (ADDR_W-1)'(EXT_OFS_LEN))      rdData = EXT_LEN;
      else if (addr[ADDR_W-2:0] == (ADDR_W-1)'(EXT_OFS_ORD)) rdData = bigEnd ? ORDER_BIG : ORDER_LITTLE;
    end else if (idx == IDX_ID)   rdData = {16'h0, ID_CODE};
    else if (idx == IDX_MEM)      rdData = {16'h0, MEM_BLOCKS};
    else if (idx >= IDX_W'(NUM_IDX)) rdData = 32'h0000_FFFF;
    else                          rdData = {16'h0, regFile[idx]};
  end

  // derive the requested mode
  modeInfo_t        cur;
  logic             depthOk;
  logic [REG_W-1:0] effW;
  logic [GEO_W:0]   endAddr;

  always_comb begin
    cur     = '0;
    depthOk = 1'b1;
    case (regFile[IDX_DEPTH])
      16'd16: begin cur.bpp = 3'd2; cur.fmt = FMT_RGB565; end
      16'd32: begin cur.bpp = 3'd4; cur.fmt = bigEnd ? FMT_XRGB_BE : FMT_XRGB_LE; end
      default: depthOk = 1'b0;
    endcase
    cur.width  = regFile[IDX_XRES];
    cur.height = regFile[IDX_YRES];
    effW       = (regFile[IDX_VIRTW] < cur.width) ? cur.width : regFile[IDX_VIRTW];
    cur.stride = STR_W'(effW) * STR_W'(cur.bpp);
    cur.size   = GEO_W'(cur.stride) * GEO_W'(cur.height);
    cur.offset = GEO_W'(regFile[IDX_XPAN]) * GEO_W'(cur.bpp)
               + GEO_W'(regFile[IDX_YPAN]) * GEO_W'(cur.stride);
    endAddr    = {1'b0, cur.offset} + {1'b0, cur.size};
    curValid   = regFile[IDX_EN][0] && depthOk
              && cur.width >= REG_W'(MIN_DIM) && cur.height >= REG_W'(MIN_DIM)
              && endAddr <= MEM_LIMIT;
  end

  assign modeDiffers = (cur != latched);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latched <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= curValid;
      if (strobe.latch) latched <= cur;
    end
  end
endmodule

// File: rtl/fb_mode_bank.sv
module fb_mode_bank
  import fb_mode_pkg::*;
#(
  parameter longint unsigned MEM_REQ_BYTES = 64'd16777216
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [9:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        modeValid,
  output logic        modeChanged,
  output logic [1:0]  pixFormat,
  output logic [2:0]  bytesPerPix,
  output logic [15:0] modeWidth,
  output logic [15:0] modeHeight,
  output logic [17:0] modeStride,
  output logic [35:0] modeOffset,
  output logic [35:0] modeSize
);
  localparam longint unsigned MEM_BYTES = pow2Ceil(MEM_REQ_BYTES);

  ctlStrobe_t strobe;
  modeInfo_t  latched;
  logic       curValid;
  logic       modeDiffers;

  fb_mode_ctl ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .curValid(curValid), .modeDiffers(modeDiffers),
    .strobe(strobe), .modeChanged(modeChanged)
  );

  fb_mode_dp #(.MEM_BYTES(MEM_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .rdData(rdData), .curValid(curValid), .modeDiffers(modeDiffers),
    .validQ(modeValid), .latched(latched)
  );

  assign pixFormat   = latched.fmt;
  assign bytesPerPix = latched.bpp;
  assign modeWidth   = latched.width;
  assign modeHeight  = latched.height;
  assign modeStride  = latched.stride;
  assign modeOffset  = latched.offset;
  assign modeSize    = latched.size;
endmodule

// File: rtl/fb_mode_bank_chk.sv
module fb_mode_bank_chk
  import fb_mode_pkg::*;
#(
  parameter longint unsigned MEM_REQ_BYTES = 64'd16777216
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [9:0]  addr,
  input logic [31:0] rdData,
  input logic        modeValid,
  input logic        modeChanged,
  input logic [1:0]  pixFormat,
  input logic [2:0]  bytesPerPix,
  input logic [15:0] modeWidth,
  input logic [15:0] modeHeight,
  input logic [17:0] modeStride,
  input logic [35:0] modeOffset,
  input logic [35:0] modeSize
);
  localparam longint unsigned MEM_BYTES = pow2Ceil(MEM_REQ_BYTES);

  initial begin
    p_mem_range_r3: assert (MEM_REQ_BYTES >= 64'd4194304 && MEM_REQ_BYTES <= 64'd268435456);
  end

  p_id_const_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!addr[9] && addr[8:1] == 8'd0) |-> rdData == 32'h0000_4C46);

  p_beyond_ones_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!addr[9] && addr[8:1] >= 8'd9) |-> rdData == 32'h0000_FFFF);

  p_ext_len_r11: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 10'h200) |-> rdData == 32'd8);

  p_order_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 10'h204) |-> (rdData == ORDER_BIG || rdData == ORDER_LITTLE));

  p_fit_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> (modeWidth >= 16'd64 && modeHeight >= 16'd64
                   && ({1'b0, modeOffset} + {1'b0, modeSize}) <= 37'(MEM_BYTES)));

  p_format_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> ((pixFormat == 2'd1 && bytesPerPix == 3'd2)
                || (pixFormat >= 2'd2 && bytesPerPix == 3'd4)));

  p_stride_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> (modeStride >= 18'(modeWidth) * 18'(bytesPerPix)
                && modeSize == 36'(modeStride) * 36'(modeHeight)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !modeChanged |-> ($stable(modeWidth) && $stable(modeStride)
                   && $stable(modeOffset) && $stable(pixFormat)));

  p_pulse_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    modeChanged |-> modeValid);

  logic unusedWr;
  assign unusedWr = wrEn;
endmodule

bind fb_mode_bank fb_mode_bank_chk #(.MEM_REQ_BYTES(MEM_REQ_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .rdData(rdData),
  .modeValid(modeValid), .modeChanged(modeChanged), .pixFormat(pixFormat),
  .bytesPerPix(bytesPerPix), .modeWidth(modeWidth), .modeHeight(modeHeight),
  .modeStride(modeStride), .modeOffset(modeOffset), .modeSize(modeSize)
);

// File: tb/fb_mode_bank_tb_top.sv
module fb_mode_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        modeValid, modeChanged;
  logic [1:0]  pixFormat;
  logic [2:0]  bytesPerPix;
  logic [15:0] modeWidth, modeHeight;
  logic [17:0] modeStride;
  logic [35:0] modeOffset, modeSize;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  // 5 MiB requested, 8 MiB installed after rounding
  fb_mode_bank #(.MEM_REQ_BYTES(64'd5242880)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .modeValid(modeValid), .modeChanged(modeChanged),
    .pixFormat(pixFormat), .bytesPerPix(bytesPerPix), .modeWidth(modeWidth),
    .modeHeight(modeHeight), .modeStride(modeStride), .modeOffset(modeOffset),
    .modeSize(modeSize)
  );

  typedef struct packed {
    logic [15:0] depth, xres, yres, virtW, xpan, ypan;
    logic        ok;
    logic [2:0]  bpp;
    logic [31:0] stride, size, offset;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd32, 16'd640,  16'd480,  16'd0,    16'd0,  16'd0, 1'b1, 3'd4, 32'd2560, 32'd1228800, 32'd0},
    '{16'd16, 16'd800,  16'd600,  16'd1024, 16'd10, 16'd5, 1'b1, 3'd2, 32'd2048, 32'd1228800, 32'd10260},
    '{16'd24, 16'd800,  16'd600,  16'd0,    16'd0,  16'd0, 1'b0, 3'd0, 32'd0,    32'd0,       32'd0},
    '{16'd32, 16'd63,   16'd100,  16'd0,    16'd0,  16'd0, 1'b0, 3'd0, 32'd0,    32'd0,       32'd0},
    '{16'd32, 16'd64,   16'd64,   16'd0,    16'd0,  16'd0, 1'b1, 3'd4, 32'd256,  32'd16384,   32'd0},
    '{16'd32, 16'd1024, 16'd2048, 16'd1024, 16'd0,  16'd0, 1'b1, 3'd4, 32'd4096, 32'd8388608, 32'd0},
    '{16'd32, 16'd1024, 16'd2048, 16'd1024, 16'd1,  16'd0, 1'b0, 3'd0, 32'd0,    32'd0,       32'd0},
    '{16'd16, 16'd1000, 16'd100,  16'd500,  16'd0,  16'd3, 1'b1, 3'd2, 32'd2000, 32'd200000,  32'd6000}
  };

  function automatic logic [9:0] mA(input int idx);
    return {1'b0, 8'(idx), 1'b0};
  endfunction
  function automatic logic [9:0] xA(input int ofs);
    return {1'b1, 9'(ofs)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [9:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("reset R12 valid", 64'(modeValid), 0);
    chk("reset R12 pulse", 64'(modeChanged), 0);
    chk("reset R12 width", 64'(modeWidth), 0);
    busRd(mA(3), rd);     chk("reset R1 xres", 64'(rd), 0);
    busRd(xA(4), rd);     chk("reset R10 order", 64'(rd), 64'h1E1E1E1E);

    // fixed words
    busWr(mA(0), 32'h1234);
    busRd(mA(0), rd);     chk("R2 id", 64'(rd), 64'h4C46);
    busRd(mA(8), rd);     chk("R3 mem blocks", 64'(rd), 128);
    busRd(mA(9), rd);     chk("R4 beyond 9", 64'(rd), 64'hFFFF);
    busRd(mA(200), rd);   chk("R4 beyond 200", 64'(rd), 64'hFFFF);
    busRd(xA(0), rd);     chk("R11 ext len", 64'(rd), 8);
    busRd(xA(8), rd);     chk("R11 ext other", 64'(rd), 0);

    // plain storage
    busWr(mA(3), 32'hFFFF_0123);
    busRd(mA(3), rd);     chk("R1 xres readback", 64'(rd), 64'h0123);

    // table walk with enable set
    busWr(mA(1), 32'd1);
    for (int i = 0; i < NV; i++) begin
      busWr(mA(2), 32'(VECS[i].depth));
      busWr(mA(3), 32'(VECS[i].xres));
      busWr(mA(4), 32'(VECS[i].yres));
      busWr(mA(5), 32'(VECS[i].virtW));
      busWr(mA(6), 32'(VECS[i].xpan));
      busWr(mA(7), 32'(VECS[i].ypan));
      @(negedge clk);
      chk($sformatf("R9 R5 valid v%0d", i), 64'(modeValid), 64'(VECS[i].ok));
      if (VECS[i].ok) begin
        chk($sformatf("R6 bpp v%0d", i), 64'(bytesPerPix), 64'(VECS[i].bpp));
        chk($sformatf("R7 stride v%0d", i), 64'(modeStride), 64'(VECS[i].stride));
        chk($sformatf("R7 size v%0d", i), 64'(modeSize), 64'(VECS[i].size));
        chk($sformatf("R8 offset v%0d", i), 64'(modeOffset), 64'(VECS[i].offset));
        chk($sformatf("R1 width v%0d", i), 64'(modeWidth), 64'(VECS[i].xres));
      end
    end
    chk("R6 fmt rgb565", 64'(pixFormat), 1);

    // pulse timing: change width on a valid mode (virtual width 500 < 1001)
    busWr(mA(3), 32'd1001);
    chk("R12 no early pulse", 64'(modeChanged), 0);
    @(negedge clk);
    chk("R12 pulse", 64'(modeChanged), 1);
    chk("R12 new width", 64'(modeWidth), 1001);
    chk("R7 stride from width", 64'(modeStride), 2002);
    @(negedge clk);
    chk("R12 pulse ends", 64'(modeChanged), 0);

    // disable holds, identical re-enable gives no pulse
    busWr(mA(1), 32'd0);
    @(negedge clk);
    chk("R5 disabled", 64'(modeValid), 0);
    chk("R12 held width", 64'(modeWidth), 1001);
    chk("R12 no pulse on disable", 64'(modeChanged), 0);
    busWr(mA(1), 32'd1);
    @(negedge clk);
    chk("R5 re-enabled", 64'(modeValid), 1);
    chk("R12 same mode no pulse", 64'(modeChanged), 0);

    // byte order
    busWr(mA(2), 32'd32);
    @(negedge clk);
    chk("R6 fmt xrgb le", 64'(pixFormat), 2);
    chk("R6 bpp 4", 64'(bytesPerPix), 4);
    busWr(xA(4), 32'hBEBE_BEBE);
    @(negedge clk);
    chk("R10 fmt be", 64'(pixFormat), 3);
    chk("R10 pulse on order", 64'(modeChanged), 1);
    busRd(xA(4), rd);     chk("R10 read be", 64'(rd), 64'hBEBEBEBE);
    busWr(xA(4), 32'h1234_5678);
    @(negedge clk);
    busRd(xA(4), rd);     chk("R10 other value ignored", 64'(rd), 64'hBEBEBEBE);
    chk("R10 fmt kept", 64'(pixFormat), 3);
    busWr(xA(4), 32'h1E1E_1E1E);
    @(negedge clk);
    busRd(xA(4), rd);     chk("R10 read le", 64'(rd), 64'h1E1E1E1E);
    chk("R10 fmt le", 64'(pixFormat), 2);

    // writes to read-only and out-of-range indices
    busWr(mA(8), 32'h0);
    busWr(mA(9), 32'h0);
    busWr(mA(11), 32'h0);
    @(negedge clk);
    busRd(mA(8), rd);     chk("R4 mem index unchanged", 64'(rd), 128);
    busRd(mA(3), rd);     chk("R4 xres unchanged", 64'(rd), 1001);
    busRd(mA(1), rd);     chk("R4 enable unchanged", 64'(rd), 1);
    chk("R4 mode unchanged", 64'(modeWidth), 1001);
    chk("R4 still valid", 64'(modeValid), 1);

    finishRun();
  end
endmodule